// File: doc/BRIEF.md
# Program Fetch Source Selector

This block stands between the instruction fetch port of an 8-bit microcontroller core and its two program stores: an on-chip code store of 62 KB and an off-chip program memory reached through a request/acknowledge bus. While reset is held, it samples a strap input. A high strap selects internal execution and a low strap selects external execution. The choice is kept in a register until the next reset. Pin activity after reset has no effect on it.

In internal mode a fetch inside the on-chip range returns the stored byte one cycle after the request. A fetch in the 2 KB window above the on-chip range (F800h to FFFFh) returns the no-operation opcode 00h with the same latency. Such a fetch never spills onto the external bus. In external mode every address, including that top window, goes to the external bus. The fetched byte comes back one cycle after the bus acknowledges. Every completed fetch ends with a one-cycle valid pulse that carries the byte.

The on-chip store is modelled as a read-only pattern. The byte at address A is `rot4(A[7:0]) ^ A[15:8] ^ A5h`, where rot4 swaps the two nibbles. A bench can therefore predict every location without a memory image.

Top module: `fetch_src_sel`

## Requirements
- R1: While `rst_n` is low, the mode register follows `strap_i`. With `strap_i`=1 at the release of reset, later fetches are served internally. With `strap_i`=0 at the release of reset, later fetches go to the external bus.
- R2: After reset is released, changes on `strap_i` have no effect on where fetches go until the next reset.
- R3: In internal mode, a request accepted at clock edge t to an address at or below F7FFh gives `fetch_valid_o`=1 after edge t+1. The data is the pattern byte `rot4(A[7:0]) ^ A[15:8] ^ A5h`.
- R4: In internal mode, a request to an address from F800h to FFFFh gives `fetch_valid_o`=1 after edge t+1 with data 00h.
- R5: In internal mode, `xbus_req_o` stays low at all times, including for fetches in the top window.
- R6: In external mode, a request accepted at edge t drives `xbus_req_o`=1 and `xbus_addr_o`=A after edge t. Both hold stable until the acknowledge is sampled. This applies to every address, including F800h to FFFFh.
- R7: In external mode, at the edge where `xbus_req_o` and `xbus_ack_i` are both high, the byte on `xbus_rdata_i` is captured and `xbus_req_o` falls. `fetch_valid_o`=1 with that byte follows right after that edge.
- R8: A request made while an external fetch is outstanding (`xbus_req_o`=1) is ignored. It is not queued and it does not change the bus address.
- R9: `fetch_valid_o` is a pulse lasting one cycle for each accepted fetch, and it never rises without a fetch. During reset `fetch_valid_o` and `xbus_req_o` are 0.
- R10: In internal mode a new request is accepted on every clock. Back-to-back fetches return their bytes in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is sampled while it is low |
| strap_i | input | 1 | Execution-source strap, 1 = internal, 0 = external |
| fetch_req_i | input | 1 | Fetch request from the core |
| fetch_addr_i | input | 16 | Fetch address |
| fetch_rdata_o | output | 8 | Fetched byte, valid with `fetch_valid_o` |
| fetch_valid_o | output | 1 | One-cycle pulse marking a returned byte |
| xbus_req_o | output | 1 | External program bus request |
| xbus_addr_o | output | 16 | External program bus address |
| xbus_ack_i | input | 1 | External bus acknowledge |
| xbus_rdata_i | input | 8 | External bus read data |

## Verification
The bench concentrates on the boundary between F7FFh and F800h in both modes. A design that rolled over into external memory would raise `xbus_req_o` in internal mode. A design that substituted the no-operation opcode in external mode would return 00h where the bench expects the bus byte. It also strays from the strap after reset and issues requests during long acknowledge waits. These catch a mode register that keeps tracking the pin, and a bus port that re-latches or queues a second address. Random back-to-back internal streams expose an off-by-one latency or a valid that stays high for more than one cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  localparam int unsigned DEF_ADDR_W   = 16;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam logic [15:0] DEF_TOP_ADDR = 16'hF7FF;
  localparam logic [7:0]  DEF_NOP      = 8'h00;
  localparam logic [7:0]  DEF_SEED     = 8'hA5;

  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_INTERNAL = 1'b1
  } fetch_src_e;

endpackage

// File: rtl/pfs_mode_latch.sv
module pfs_mode_latch
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_i,
  output fetch_src_e src_o
);

  fetch_src_e src_q;

  // the strap is followed only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= strap_i ? SRC_INTERNAL : SRC_EXTERNAL;
    end
  end

  assign src_o = src_q;

  assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(src_q));

endmodule

// File: rtl/pfs_int_store.sv
module pfs_int_store #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] TOP_ADDR = 16'hF7FF,
  parameter logic [DATA_W-1:0] NOP_BYTE = 8'h00,
  parameter logic [DATA_W-1:0] SEED     = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_was_nop_o
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam bit HAS_WINDOW = (TOP_ADDR != ADDR_MAX);

  // content of the on-chip code store, computed from the address
  function automatic logic [DATA_W-1:0] code_byte(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] lo;
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] rot;
    lo  = a[DATA_W-1:0];
    hi  = DATA_W'(a >> DATA_W);
    rot = {lo[HALF_W-1:0], lo[DATA_W-1:HALF_W]};
    return rot ^ hi ^ SEED;
  endfunction

  logic in_window;

  generate
    if (HAS_WINDOW) begin : g_window
      assign in_window = (rd_addr_i > TOP_ADDR);
    end else begin : g_nowindow
      assign in_window = 1'b0;
    end
  endgenerate

  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              nop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      nop_q   <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      nop_q   <= rd_en_i && in_window;
      if (rd_en_i) begin
        data_q <= in_window ? NOP_BYTE : code_byte(rd_addr_i);
      end
    end
  end

  assign rd_data_o    = data_q;
  assign rd_valid_o   = valid_q;
  assign rd_was_nop_o = nop_q;

  assert_window_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && in_window) |=> (rd_valid_o && rd_data_o == NOP_BYTE));

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);

endmodule

// File: rtl/pfs_ext_port.sv
module pfs_ext_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  output logic              xbus_req_o,
  output logic [ADDR_W-1:0] xbus_addr_o,
  input  logic              xbus_ack_i,
  input  logic [DATA_W-1:0] xbus_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] done_data_o
);

  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic              handshake;
  logic              launch;

  assign handshake = req_q && xbus_ack_i;
  assign launch    = start_i && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= handshake;
      if (handshake) begin
        req_q  <= 1'b0;
        data_q <= xbus_rdata_i;
      end else if (launch) begin
        req_q  <= 1'b1;
        addr_q <= start_addr_i;
      end
    end
  end

  assign busy_o      = req_q;
  assign xbus_req_o  = req_q;
  assign xbus_addr_o = addr_q;
  assign done_o      = done_q;
  assign done_data_o = data_q;

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_req_o && !xbus_ack_i) |=> (xbus_req_o && $stable(xbus_addr_o)));

  assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_req_o && xbus_ack_i) |=> (!xbus_req_o && done_o));

  assert_no_requeue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xbus_req_o && start_i) |=> $stable(xbus_addr_o));

endmodule

// File: rtl/fetch_src_sel.sv
module fetch_src_sel
  import pfs_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] TOP_ADDR = DEF_TOP_ADDR,
  parameter logic [DATA_W-1:0] NOP_BYTE = DEF_NOP,
  parameter logic [DATA_W-1:0] SEED     = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [DATA_W-1:0] fetch_rdata_o,
  output logic              fetch_valid_o,
  output logic              xbus_req_o,
  output logic [ADDR_W-1:0] xbus_addr_o,
  input  logic              xbus_ack_i,
  input  logic [DATA_W-1:0] xbus_rdata_i
);

  fetch_src_e src;
  logic       ext_busy;
  logic       fetch_accept;
  logic       int_launch;
  logic       ext_launch;
  logic [DATA_W-1:0] int_data;
  logic       int_valid;
  logic       int_nop;
  logic [DATA_W-1:0] ext_data;
  logic       ext_done;

  pfs_mode_latch u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .src_o   (src)
  );

  // named fetch events
  assign fetch_accept = fetch_req_i && !ext_busy;
  assign int_launch   = fetch_accept && (src == SRC_INTERNAL);
  assign ext_launch   = fetch_accept && (src == SRC_EXTERNAL);

  pfs_int_store #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TOP_ADDR (TOP_ADDR),
    .NOP_BYTE (NOP_BYTE),
    .SEED     (SEED)
  ) u_int (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en_i      (int_launch),
    .rd_addr_i    (fetch_addr_i),
    .rd_data_o    (int_data),
    .rd_valid_o   (int_valid),
    .rd_was_nop_o (int_nop)
  );

  pfs_ext_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ext (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (ext_launch),
    .start_addr_i (fetch_addr_i),
    .busy_o       (ext_busy),
    .xbus_req_o   (xbus_req_o),
    .xbus_addr_o  (xbus_addr_o),
    .xbus_ack_i   (xbus_ack_i),
    .xbus_rdata_i (xbus_rdata_i),
    .done_o       (ext_done),
    .done_data_o  (ext_data)
  );

  assign fetch_valid_o = int_valid || ext_done;
  assign fetch_rdata_o = int_valid ? int_data : ext_data;

  assert_no_rollover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_INTERNAL) |-> !xbus_req_o);

  assert_single_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_valid, ext_done}));

  assert_nop_only_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_nop |-> (src == SRC_INTERNAL && fetch_valid_o));

  assert_ext_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_launch |=> (xbus_req_o && xbus_addr_o == $past(fetch_addr_i)));

  assert_stream_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_launch |=> fetch_valid_o);

endmodule

// File: tb/sim_fetch_src_sel.sv
module sim_fetch_src_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_i = 1'b1;
  logic        fetch_req_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic [7:0]  fetch_rdata_o;
  logic        fetch_valid_o;
  logic        xbus_req_o;
  logic [15:0] xbus_addr_o;
  logic        xbus_ack_i = 1'b0;
  logic [7:0]  xbus_rdata_i = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fetch_src_sel u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i),
    .fetch_rdata_o(fetch_rdata_o), .fetch_valid_o(fetch_valid_o),
    .xbus_req_o(xbus_req_o), .xbus_addr_o(xbus_addr_o),
    .xbus_ack_i(xbus_ack_i), .xbus_rdata_i(xbus_rdata_i)
  );

  // expected internal byte: nibble swap of low byte, xor high byte, xor A5h
  function automatic logic [7:0] exp_internal(input logic [15:0] a);
    logic [7:0] sw;
    sw = (a[7:0] << 4) | (a[7:0] >> 4);
    if (a >= 16'hF800) return 8'h00;
    return sw ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_i = strap;
    fetch_req_i = 1'b0;
    xbus_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    check(fetch_valid_o == 1'b0, "R9", "valid in reset", fetch_valid_o, 0);
    check(xbus_req_o == 1'b0, "R9", "bus req in reset", xbus_req_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one internal fetch; caller is at a negedge
  task automatic int_fetch(input logic [15:0] a, input string req);
    fetch_req_i = 1'b1;
    fetch_addr_i = a;
    @(negedge clk);
    fetch_req_i = 1'b0;
    check(fetch_valid_o == 1'b1, req, "valid after one cycle", fetch_valid_o, 1);
    check(fetch_rdata_o == exp_internal(a), req, "internal data",
          fetch_rdata_o, exp_internal(a));
    check(xbus_req_o == 1'b0, "R5", "no bus request in internal mode", xbus_req_o, 0);
    @(negedge clk);
    check(fetch_valid_o == 1'b0, "R9", "valid one cycle", fetch_valid_o, 0);
  endtask

  // one external fetch with wait cycles; optionally pester with requests
  task automatic ext_fetch(input logic [15:0] a, input int waits,
                           input logic [7:0] d, input bit pester);
    fetch_req_i = 1'b1;
    fetch_addr_i = a;
    @(negedge clk);
    check(xbus_req_o == 1'b1, "R6", "bus request raised", xbus_req_o, 1);
    check(xbus_addr_o == a, "R6", "bus address", xbus_addr_o, a);
    check(fetch_valid_o == 1'b0, "R9", "no valid before ack", fetch_valid_o, 0);
    fetch_req_i = pester;
    fetch_addr_i = ~a;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      check(xbus_req_o == 1'b1 && xbus_addr_o == a, pester ? "R8" : "R6",
            "request held", {15'd0, xbus_req_o, xbus_addr_o}, {15'd1, 1'b0, a});
      check(fetch_valid_o == 1'b0, "R7", "no valid while waiting", fetch_valid_o, 0);
    end
    xbus_ack_i = 1'b1;
    xbus_rdata_i = d;
    @(negedge clk);
    fetch_req_i = 1'b0;
    xbus_ack_i = 1'b0;
    xbus_rdata_i = ~d;
    check(fetch_valid_o == 1'b1, "R7", "valid after ack", fetch_valid_o, 1);
    check(fetch_rdata_o == d, "R7", "bus data returned", fetch_rdata_o, d);
    check(xbus_req_o == 1'b0, pester ? "R8" : "R7", "request dropped, nothing queued",
          xbus_req_o, 0);
    @(negedge clk);
    check(fetch_valid_o == 1'b0, "R9", "valid one cycle", fetch_valid_o, 0);
    check(xbus_req_o == 1'b0, "R8", "no queued request", xbus_req_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    void'($urandom(32'd2718));

    // R1: internal mode, boundaries
    do_reset(1'b1);
    int_fetch(16'h0000, "R3");
    int_fetch(16'hF7FF, "R3");
    int_fetch(16'hF800, "R4");
    int_fetch(16'hFFFF, "R4");
    int_fetch(16'h1234, "R1");

    // R2: strap changes after reset ignored
    strap_i = 1'b0;
    int_fetch(16'h00A0, "R2");
    int_fetch(16'hFC00, "R2");
    repeat (5) @(negedge clk);
    check(xbus_req_o == 1'b0, "R2", "strap toggle no bus", xbus_req_o, 0);

    // R10: random back-to-back stream
    fetch_req_i = 1'b1;
    prev = 16'($urandom());
    fetch_addr_i = prev;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] nxt;
      nxt = (i % 7 == 3) ? (16'hF800 | 16'($urandom() & 32'h7FF)) : 16'($urandom());
      @(negedge clk);
      check(fetch_valid_o == 1'b1 && fetch_rdata_o == exp_internal(prev), "R10",
            "stream byte", {fetch_valid_o, fetch_rdata_o}, {1'b1, exp_internal(prev)});
      check(xbus_req_o == 1'b0, "R5", "stream no bus", xbus_req_o, 0);
      prev = nxt;
      fetch_addr_i = nxt;
    end
    fetch_req_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(fetch_valid_o == 1'b0, "R9", "idle after stream", fetch_valid_o, 0);

    // R1: external mode
    do_reset(1'b0);
    strap_i = 1'b1;
    ext_fetch(16'h0100, 0, 8'h3C, 1'b0);
    ext_fetch(16'hF7FF, 2, 8'h77, 1'b0);
    ext_fetch(16'hF800, 1, 8'h5E, 1'b0);
    ext_fetch(16'hFFFF, 4, 8'hC3, 1'b1);
    for (int i = 0; i < 60; i++) begin
      ext_fetch(16'($urandom()), int'($urandom() % 6), 8'($urandom()),
                1'($urandom()));
    end
    repeat (4) @(negedge clk);
    check(fetch_valid_o == 1'b0, "R9", "no spurious valid", fetch_valid_o, 0);

    // R1: back to internal after a new reset
    do_reset(1'b1);
    int_fetch(16'hF9AB, "R1");
    int_fetch(16'h5A5A, "R1");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule